// File: doc/BRIEF.md
# Transmit deferral and missing-carrier statistics

This block sits beside the transmit path of an Ethernet MAC and keeps two clear-on-read statistics counters. The first counts deferrals: occasions when a frame is waiting to go out but cannot start. The causes are a busy medium, an unexpired inter-packet gap, a half-duplex hold-off, a received pause (XOFF) frame or a link that is down. Each waiting frame is counted at most once. A wait caused only by the inter-packet gap while frames are streaming back to back is not counted.

The second counter records successful half-duplex transmissions during which the PHY never raised carrier sense inside the slot-time window. The window opens on the cycle in which the transmit enable first rises. Its length in clock cycles depends on the link speed. Full-duplex operation and serial-PHY mode suppress this counter. Both counters count only while transmission is enabled. A counter stops at all ones. When software reads a counter, the counter clears, and an event in the same cycle as the read leaves the count at one.

Top module: `txdefer_stats`

## Requirements
- R1: After reset both counters read zero.
- R2: While `frame_pend` is high and `tx_enable` is high, any one of `cause_busy`, `cause_hdx`, `cause_xoff`, `cause_linkdown` or (`cause_ipg` with `streaming` low) adds one to `defer_count`, visible on the cycle after the cause is first sampled.
- R3: A pending frame held back only by `cause_ipg` while `streaming` is high is not counted. If another cause also applies, the frame is counted.
- R4: A pending frame adds at most one to `defer_count`, however many cycles it waits and however many causes apply. The count re-arms once `frame_pend` has been low for a cycle.
- R5: While `tx_enable` is low, neither counter increments.
- R6: A `tx_ok` pulse adds one to `nocrs_count` unless `crs` was high in some cycle of the window that starts with the cycle in which `tx_en` rises.
- R7: The window covers SLOT_10 cycles when `speed` is 2'b00, SLOT_100 cycles when it is 2'b01 and SLOT_1000 cycles when it is 2'b10 or 2'b11. The rise cycle is offset 0, so a `crs` first high at offset SLOT-1 suppresses the count and one first high at offset SLOT does not. The speed is sampled at the rise.
- R8: While `full_duplex` or `sgmii` is high, `nocrs_count` does not increment.
- R9: A read strobe (`rd_defer`, `rd_nocrs`) leaves the value unchanged in the read cycle. On the next cycle the value is zero, or one if an event of that counter occurred in the read cycle.
- R10: A counter at all ones stays at all ones on further events until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmission enabled; gates both counters |
| frame_pend | input | 1 | A frame is ready and waiting to start |
| cause_busy | input | 1 | Medium busy with another station |
| cause_ipg | input | 1 | Inter-packet gap not yet expired |
| cause_hdx | input | 1 | Half-duplex hold-off in effect |
| cause_xoff | input | 1 | Paused by a received XOFF frame |
| cause_linkdown | input | 1 | Link is down |
| streaming | input | 1 | Current frame follows the previous one back to back |
| tx_en | input | 1 | Transmit enable driven to the PHY |
| crs | input | 1 | Carrier sense from the PHY |
| tx_ok | input | 1 | One-cycle pulse: transmission completed successfully |
| full_duplex | input | 1 | Link runs in full duplex |
| sgmii | input | 1 | Serial PHY interface mode |
| speed | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1000 Mb/s |
| rd_defer | input | 1 | Read strobe for the deferral counter |
| rd_nocrs | input | 1 | Read strobe for the missing-carrier counter |
| defer_count | output | CNT_W | Deferral events counted |
| nocrs_count | output | CNT_W | Transmissions without carrier inside the window |

## Verification
The hardest cases are the window edges. A carrier that first appears on the last cycle inside the window and a carrier that first appears on the first cycle outside it must differ by exactly one count. Each speed setting has its own window length. To reach these cases, the bench makes the window lengths small and drives frames with a carrier onset placed at a chosen offset from the transmit-enable rise, at each speed in turn. Saturation is reached by narrowing the counters and running more frames than they can hold. A read is also placed in the exact cycle of an event to show the cleared counter restarting at one.

// File: rtl/txdefer_stats.sv
module txdefer_stats #(
  parameter int CNT_W     = 32,
  parameter int SLOT_10   = 6400,
  parameter int SLOT_100  = 640,
  parameter int SLOT_1000 = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             frame_pend,
  input  logic             cause_busy,
  input  logic             cause_ipg,
  input  logic             cause_hdx,
  input  logic             cause_xoff,
  input  logic             cause_linkdown,
  input  logic             streaming,
  input  logic             tx_en,
  input  logic             crs,
  input  logic             tx_ok,
  input  logic             full_duplex,
  input  logic             sgmii,
  input  logic [1:0]       speed,
  input  logic             rd_defer,
  input  logic             rd_nocrs,
  output logic [CNT_W-1:0] defer_count,
  output logic [CNT_W-1:0] nocrs_count
);

  localparam int SLOT_MAX = (SLOT_10 > SLOT_100) ?
                            ((SLOT_10 > SLOT_1000) ? SLOT_10 : SLOT_1000) :
                            ((SLOT_100 > SLOT_1000) ? SLOT_100 : SLOT_1000);
  localparam int WIN_W = $clog2(SLOT_MAX + 1);

  logic             txen_q;
  logic             defer_done;
  logic             crs_seen;
  logic [WIN_W-1:0] win_left;
  logic [WIN_W-1:0] slot_load;

  wire defer_qual = cause_busy | cause_hdx | cause_xoff | cause_linkdown |
                    (cause_ipg & ~streaming);
  wire defer_evt  = tx_enable & frame_pend & defer_qual & ~defer_done;

  wire txen_rise  = tx_en & ~txen_q;
  wire in_window  = txen_rise | (win_left != '0);
  wire carrier_ok = (crs & in_window) | (~txen_rise & crs_seen);
  wire nocrs_evt  = tx_enable & tx_ok & ~full_duplex & ~sgmii & ~carrier_ok;

  always_comb begin
    case (speed)
      2'b00:   slot_load = WIN_W'(SLOT_10 - 1);
      2'b01:   slot_load = WIN_W'(SLOT_100 - 1);
      default: slot_load = WIN_W'(SLOT_1000 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q     <= 1'b0;
      defer_done <= 1'b0;
      crs_seen   <= 1'b0;
      win_left   <= '0;
    end else begin
      txen_q     <= tx_en;
      defer_done <= frame_pend & (defer_done | defer_evt);
      if (txen_rise) begin
        win_left <= slot_load;
        crs_seen <= crs;
      end else if (win_left != '0) begin
        win_left <= win_left - 1'b1;
        crs_seen <= crs_seen | crs;
      end
    end
  end

  logic [1:0][CNT_W-1:0] cnt;
  wire  [1:0]            evt = {nocrs_evt, defer_evt};
  wire  [1:0]            rd  = {rd_nocrs, rd_defer};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (rd[i])
        cnt[i] <= CNT_W'(evt[i]);
      else if (evt[i] && cnt[i] != '1)
        cnt[i] <= cnt[i] + 1'b1;
    end
  end

  assign defer_count = cnt[0];
  assign nocrs_count = cnt[1];

endmodule

// File: rtl/txdefer_stats_chk.sv
module txdefer_stats_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_enable,
  input logic             frame_pend,
  input logic             cause_busy,
  input logic             cause_ipg,
  input logic             cause_hdx,
  input logic             cause_xoff,
  input logic             cause_linkdown,
  input logic             streaming,
  input logic             full_duplex,
  input logic             sgmii,
  input logic             rd_defer,
  input logic             rd_nocrs,
  input logic [CNT_W-1:0] defer_count,
  input logic [CNT_W-1:0] nocrs_count
);

  // R5
  defer_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !rd_defer) |=> $stable(defer_count));

  // R5
  nocrs_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !rd_nocrs) |=> $stable(nocrs_count));

  // R8
  nocrs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_duplex || sgmii) && !rd_nocrs) |=> $stable(nocrs_count));

  // R3
  ipg_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_ipg && streaming && !cause_busy && !cause_hdx && !cause_xoff &&
     !cause_linkdown && !rd_defer) |=> $stable(defer_count));

  // R4
  defer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_defer |=> (defer_count == $past(defer_count) ||
                   defer_count == $past(defer_count) + 1'b1));

  // R9
  defer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_defer |=> (defer_count <= 1));

  // R9
  nocrs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nocrs |=> (nocrs_count <= 1));

  // R10
  defer_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_count == '1 && !rd_defer) |=> (defer_count == '1));

  // R10
  nocrs_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nocrs_count == '1 && !rd_nocrs) |=> (nocrs_count == '1));

  // R4
  idle_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_pend && !rd_defer) |=> $stable(defer_count));

endmodule

bind txdefer_stats txdefer_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .frame_pend(frame_pend),
  .cause_busy(cause_busy), .cause_ipg(cause_ipg), .cause_hdx(cause_hdx),
  .cause_xoff(cause_xoff), .cause_linkdown(cause_linkdown),
  .streaming(streaming), .full_duplex(full_duplex), .sgmii(sgmii),
  .rd_defer(rd_defer), .rd_nocrs(rd_nocrs),
  .defer_count(defer_count), .nocrs_count(nocrs_count)
);

// File: tb/txdefer_stats_test.sv
module txdefer_stats_test;

  localparam int W   = 5;
  localparam int S10 = 24;
  localparam int S100 = 16;
  localparam int S1G = 10;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 1'b1, frame_pend = 1'b0, cause_busy = 1'b0, cause_ipg = 1'b0;
  logic cause_hdx = 1'b0, cause_xoff = 1'b0, cause_linkdown = 1'b0, streaming = 1'b0;
  logic tx_en = 1'b0, crs = 1'b0, tx_ok = 1'b0, full_duplex = 1'b0, sgmii = 1'b0;
  logic [1:0] speed = 2'b00;
  logic rd_defer = 1'b0, rd_nocrs = 1'b0;
  logic [W-1:0] defer_count, nocrs_count;

  always #4 clk = ~clk;

  txdefer_stats #(.CNT_W(W), .SLOT_10(S10), .SLOT_100(S100), .SLOT_1000(S1G)) uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .frame_pend(frame_pend),
    .cause_busy(cause_busy), .cause_ipg(cause_ipg), .cause_hdx(cause_hdx),
    .cause_xoff(cause_xoff), .cause_linkdown(cause_linkdown), .streaming(streaming),
    .tx_en(tx_en), .crs(crs), .tx_ok(tx_ok), .full_duplex(full_duplex),
    .sgmii(sgmii), .speed(speed), .rd_defer(rd_defer), .rd_nocrs(rd_nocrs),
    .defer_count(defer_count), .nocrs_count(nocrs_count)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit compare_on = 1'b0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_def, m_nc, m_left, m_slot;
  bit  m_pend_counted, m_prev_en, m_got_crs;

  function automatic int bump(input int c, input bit e, input bit r);
    if (r) return e ? 1 : 0;
    if (e && c < MAXC) return c + 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_def = 0; m_nc = 0; m_left = 0;
      m_pend_counted = 0; m_prev_en = 0; m_got_crs = 0;
    end else begin
      bit blocked, d_ev, start, open, heard, n_ev;
      blocked = frame_pend && (cause_busy || cause_hdx || cause_xoff ||
                cause_linkdown || (cause_ipg && !streaming));
      d_ev = tx_enable && blocked && !m_pend_counted;
      start = tx_en && !m_prev_en;
      open = start || (m_left > 0);
      heard = (open && crs) || (!start && m_got_crs);
      n_ev = tx_enable && tx_ok && !full_duplex && !sgmii && !heard;
      m_def = bump(m_def, d_ev, rd_defer);
      m_nc = bump(m_nc, n_ev, rd_nocrs);
      m_pend_counted = frame_pend && (m_pend_counted || d_ev);
      if (start) begin
        m_slot = (speed == 2'b00) ? S10 : (speed == 2'b01) ? S100 : S1G;
        m_left = m_slot - 1;
        m_got_crs = crs;
      end else if (m_left > 0) begin
        m_left--;
        m_got_crs = m_got_crs || crs;
      end
      m_prev_en = tx_en;
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(int'(defer_count), m_def, {cur_req, " defer_count vs model"});
      chk(int'(nocrs_count), m_nc, {cur_req, " nocrs_count vs model"});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_both();
    @(negedge clk); rd_defer = 1; rd_nocrs = 1;
    @(negedge clk); rd_defer = 0; rd_nocrs = 0;
  endtask

  // causes: {linkdown, xoff, hdx, ipg, busy}
  task automatic defer_frame(input logic [4:0] causes, input bit strm,
                             input int n, input bit rd_first);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_pend = 1; streaming = strm;
      {cause_linkdown, cause_xoff, cause_hdx, cause_ipg, cause_busy} = causes;
      rd_defer = rd_first && (k == 0);
    end
    @(negedge clk);
    rd_defer = 0; frame_pend = 0; streaming = 0;
    {cause_linkdown, cause_xoff, cause_hdx, cause_ipg, cause_busy} = '0;
  endtask

  task automatic tx_frame(input int len, input int crs_at, input bit rd_at_ok);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      tx_en = 1;
      crs = (crs_at >= 0) && (k >= crs_at);
    end
    @(negedge clk);
    tx_en = 0; crs = 0; tx_ok = 1; rd_nocrs = rd_at_ok;
    @(negedge clk);
    tx_ok = 0; rd_nocrs = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(int'(defer_count), 0, "R1 defer_count in reset");
    chk(int'(nocrs_count), 0, "R1 nocrs_count in reset");
    rst_n = 1;
    compare_on = 1;
    idle(2);
    chk(int'(defer_count), 0, "R1 defer_count after reset");
    chk(int'(nocrs_count), 0, "R1 nocrs_count after reset");

    cur_req = "R2";
    for (int i = 0; i < 5; i++) defer_frame(5'b1 << i, 0, 3, 0);
    idle(1);
    chk(int'(defer_count), 5, "R2 one count per cause");

    cur_req = "R3";
    read_both();
    defer_frame(5'b00010, 1, 4, 0);
    idle(1);
    chk(int'(defer_count), 0, "R3 ipg-only while streaming ignored");
    defer_frame(5'b00011, 1, 3, 0);
    idle(1);
    chk(int'(defer_count), 1, "R3 ipg plus busy while streaming counted");

    cur_req = "R4";
    read_both();
    defer_frame(5'b11111, 0, 8, 0);
    defer_frame(5'b01000, 0, 5, 0);
    idle(1);
    chk(int'(defer_count), 2, "R4 once per frame");

    cur_req = "R5";
    read_both();
    @(negedge clk); tx_enable = 0;
    defer_frame(5'b00001, 0, 3, 0);
    tx_frame(4, -1, 0);
    @(negedge clk); tx_enable = 1;
    idle(1);
    chk(int'(defer_count), 0, "R5 defer disabled");
    chk(int'(nocrs_count), 0, "R5 nocrs disabled");

    cur_req = "R6";
    @(negedge clk); speed = 2'b10;
    tx_frame(20, 3, 0);
    tx_frame(20, -1, 0);
    tx_frame(20, 15, 0);
    idle(1);
    chk(int'(nocrs_count), 2, "R6 carrier inside vs outside window");

    cur_req = "R7";
    read_both();
    @(negedge clk); speed = 2'b00;
    tx_frame(30, S10 - 1, 0);
    tx_frame(30, S10, 0);
    @(negedge clk); speed = 2'b01;
    tx_frame(30, S100 - 1, 0);
    tx_frame(30, S100, 0);
    @(negedge clk); speed = 2'b11;
    tx_frame(30, S1G - 1, 0);
    tx_frame(30, S1G, 0);
    idle(1);
    chk(int'(nocrs_count), 3, "R7 window edge per speed");

    cur_req = "R8";
    read_both();
    @(negedge clk); full_duplex = 1;
    tx_frame(6, -1, 0);
    @(negedge clk); full_duplex = 0; sgmii = 1;
    tx_frame(6, -1, 0);
    @(negedge clk); sgmii = 0;
    idle(1);
    chk(int'(nocrs_count), 0, "R8 duplex and serial mode suppress");

    cur_req = "R9";
    defer_frame(5'b00001, 0, 2, 0);
    defer_frame(5'b00001, 0, 2, 0);
    tx_frame(4, -1, 0);
    tx_frame(4, -1, 0);
    defer_frame(5'b00100, 0, 2, 1);
    tx_frame(4, -1, 1);
    idle(1);
    chk(int'(defer_count), 1, "R9 read with coincident deferral");
    chk(int'(nocrs_count), 1, "R9 read with coincident no-carrier");
    read_both();
    idle(1);
    chk(int'(defer_count), 0, "R9 plain read clears defer");
    chk(int'(nocrs_count), 0, "R9 plain read clears nocrs");

    cur_req = "R10";
    for (int i = 0; i < MAXC + 8; i++) defer_frame(5'b10000, 0, 2, 0);
    for (int i = 0; i < MAXC + 8; i++) tx_frame(2, -1, 0);
    idle(1);
    chk(int'(defer_count), MAXC, "R10 defer saturates");
    chk(int'(nocrs_count), MAXC, "R10 nocrs saturates");
    read_both();
    idle(1);
    chk(int'(defer_count), 0, "R10 read after saturation");

    compare_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule